// File: doc/BRIEF.md
# Host-Side Converter Read Sequencer

This block sits between a simple request/response port and a 12-bit successive-approximation converter that is controlled by active-low chip-select and read strobes plus a byte-select line. On the converter, a read strobe taken with the byte-select low also starts the next conversion. The sequencer hides that pipelined behaviour. One accepted request produces exactly one fresh 12-bit sample on the result port. The sequencer generates the chip-select, read and byte-select waveforms with setup, read-width, hold and inter-read gap counts set by parameters. It also enforces a conversion guard time between a conversion-starting read and any later read.

Two modes are selected per request. In the pipelined mode, every read returns the previous result, so the sequencer issues an extra starting read and keeps only data collected after the guard time. In the waiting mode, a single read starts the conversion and the read strobe is held low until the converter's busy line, after synchronisation, has gone low and then high again. Either mode can move the word as one 12-bit parallel read or as two 8-bit reads, in which case the pieces are assembled into one word.

Top module: `adc_read_seq`

## Requirements
- R1: While reset is held and in idle afterwards, `adc_cs_n` and `adc_rd_n` are high, `res_valid` is low and `req_ready` is high.
- R2: A request transfers when `req_valid` and `req_ready` are both high. `req_slow` and `req_byte` are sampled at that transfer. `req_ready` stays low from the transfer until the result is returned, and `req_valid` has no effect in that window.
- R3: For every read, `adc_cs_n` is low at least SETUP_CYC cycles before `adc_rd_n` falls. `adc_rd_n` stays low at least PULSE_CYC cycles. `adc_cs_n` stays low at least HOLD_CYC cycles after `adc_rd_n` rises. `adc_hben` does not change while `adc_cs_n` is low. `adc_cs_n` stays high at least GAP_CYC cycles between reads.
- R4: A read whose `adc_hben` is low starts a conversion. No read of any kind begins (falling `adc_rd_n`) within CONV_CYC cycles of the previous conversion-starting read.
- R5: Pipelined parallel (`req_slow`=0, `req_byte`=0) issues two reads with `adc_hben` low. The result is all 12 bus bits from the second read.
- R6: Pipelined two-byte (`req_slow`=0, `req_byte`=1) issues three reads with `adc_hben` low, high, low. The result is bus bits 3..0 of the second read as bits 11..8, and bus bits 7..0 of the third read as bits 7..0.
- R7: Waiting parallel (`req_slow`=1, `req_byte`=0) issues one read with `adc_hben` low. `adc_rd_n` is held low until the synchronised `adc_busy_n` has been seen low and then high. The result is the 12 bus bits sampled at that point.
- R8: Waiting two-byte (`req_slow`=1, `req_byte`=1) takes result bits 7..0 from bus bits 7..0 of a waiting read with `adc_hben` low. It then takes result bits 11..8 from bus bits 3..0 of a second read with `adc_hben` high, which starts no conversion.
- R9: `res_valid` is high for exactly one cycle per accepted request, only while `req_ready` is high. No result carries data read before the first conversion after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request for one fresh sample |
| req_ready | output | 1 | High in idle; low while a request is in progress |
| req_slow | input | 1 | 1 selects the waiting mode, 0 the pipelined mode |
| req_byte | input | 1 | 1 selects two 8-bit reads, 0 one 12-bit read |
| res_valid | output | 1 | One-cycle strobe marking a fresh result; no back-pressure, the consumer must take it |
| res_data | output | 12 | Assembled sample, valid while `res_valid` is high |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_hben | output | 1 | Byte select: high reads the top nibble on bus bits 3..0 |
| adc_busy_n | input | 1 | Converter busy, low during a conversion (asynchronous) |
| adc_data | input | 12 | Converter data bus |

## Verification
The assertions take for granted that the converter's busy line drops only after a read with byte-select low, and rises again within the conversion guard time. They also assume the data bus is stable by the time the synchronised busy line reads high. A stalled waiting read or a read inside a running conversion would otherwise be blamed on the sequencer. The bench's converter model keeps to this: its conversion is shorter than the guard, and it updates its latch on the same edge that raises busy. The result port is never back-pressured, so the stimulus consumes every `res_valid`. Requests are offered only through the valid/ready rules of R2.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_WLO, ST_WHI, ST_HOLD, ST_GAP
  } strobe_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_ISSUE, SQ_WAIT
  } seq_st_t;

  // index of the final read for each mode combination
  function automatic logic [1:0] last_step(input logic slow, input logic two_byte);
    if (slow) return two_byte ? 2'd1 : 2'd0;
    else      return two_byte ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/adc_seq_guard.sv
module adc_seq_guard #(
  parameter int CONV_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic clear
);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (arm)           cnt <= CW'(CONV_CYC);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign clear = (cnt == '0);
endmodule

// File: rtl/adc_seq_strobe.sv
module adc_seq_strobe
  import adc_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int GAP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_hben,
  input  logic              start_wait,
  input  logic              busy_n_s,
  input  logic [DATA_W-1:0] bus_data,
  output logic              idle,
  output logic              done,
  output logic              done_hben,
  output logic [DATA_W-1:0] cap_data,
  output logic              cs_n,
  output logic              rd_n,
  output logic              hben
);
  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  strobe_st_t        st;
  logic [CNT_W-1:0]  cnt;
  logic              hben_q;
  logic              wait_q;
  logic              done_q;
  logic [DATA_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      hben_q <= 1'b0;
      wait_q <= 1'b0;
      done_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_SETUP;
          cnt    <= CNT_W'(SETUP_CYC - 1);
          hben_q <= start_hben;
          wait_q <= start_wait;
        end
        ST_SETUP: if (cnt == '0) begin
          st  <= ST_PULSE;
          cnt <= CNT_W'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_PULSE: if (cnt == '0) begin
          if (wait_q) st <= ST_WLO;
          else begin
            cap_q <= bus_data;
            st    <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        ST_WLO: if (!busy_n_s) st <= ST_WHI;
        ST_WHI: if (busy_n_s) begin
          cap_q <= bus_data;
          st    <= ST_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end
        ST_HOLD: if (cnt == '0) begin
          st     <= ST_GAP;
          cnt    <= CNT_W'(GAP_CYC - 1);
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_GAP: if (cnt == '0) st <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st == ST_IDLE);
  assign done      = done_q;
  assign done_hben = hben_q;
  assign cap_data  = cap_q;
  assign cs_n      = (st == ST_IDLE) || (st == ST_GAP);
  assign rd_n      = !((st == ST_PULSE) || (st == ST_WLO) || (st == ST_WHI));
  assign hben      = hben_q;
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 2,
  parameter int GAP_CYC     = 4,
  parameter int CONV_CYC    = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_slow,
  input  logic              req_byte,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              adc_hben,
  input  logic              adc_busy_n,
  input  logic [DATA_W-1:0] adc_data
);
  localparam int NIB_W = DATA_W - BYTE_W;

  seq_st_t           st;
  logic              slow_q, two_q;
  logic [1:0]        step_q;
  logic [DATA_W-1:0] word_q;
  logic              valid_q;

  logic              busy_n_s;
  logic              g_clear, s_idle, s_done, s_done_hben;
  logic [DATA_W-1:0] s_cap;
  logic              cur_hben, cur_wait, go;

  assign cur_hben = two_q && (step_q == 2'd1);
  assign cur_wait = slow_q && (step_q == 2'd0);
  assign go       = (st == SQ_ISSUE) && s_idle && g_clear;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_busy_n), .q(busy_n_s)
  );

  adc_seq_guard #(.CONV_CYC(CONV_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .arm(go && !cur_hben), .clear(g_clear)
  );

  adc_seq_strobe #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(go), .start_hben(cur_hben),
    .start_wait(cur_wait), .busy_n_s(busy_n_s), .bus_data(adc_data),
    .idle(s_idle), .done(s_done), .done_hben(s_done_hben), .cap_data(s_cap),
    .cs_n(adc_cs_n), .rd_n(adc_rd_n), .hben(adc_hben)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      slow_q  <= 1'b0;
      two_q   <= 1'b0;
      step_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        SQ_IDLE: if (req_valid) begin
          slow_q <= req_slow;
          two_q  <= req_byte;
          step_q <= '0;
          st     <= SQ_ISSUE;
        end
        SQ_ISSUE: if (go) st <= SQ_WAIT;
        SQ_WAIT: if (s_done) begin
          // stale reads are simply overwritten by the later ones
          if (s_done_hben)  word_q[DATA_W-1:BYTE_W] <= s_cap[NIB_W-1:0];
          else if (two_q)   word_q[BYTE_W-1:0]      <= s_cap[BYTE_W-1:0];
          else              word_q                  <= s_cap;
          if (step_q == last_step(slow_q, two_q)) begin
            st      <= SQ_IDLE;
            valid_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
            st     <= SQ_ISSUE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready = (st == SQ_IDLE);
  assign res_valid = valid_q;
  assign res_data  = word_q;
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk #(
  parameter int CONV_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic adc_cs_n,
  input logic adc_rd_n,
  input logic adc_hben,
  input logic res_valid
);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic          rd_q;
  logic [CW-1:0] since_q;
  logic          rd_fall;

  assign rd_fall = rd_q && !adc_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b1;
      since_q <= CW'(CONV_CYC);
    end else begin
      rd_q <= adc_rd_n;
      if (rd_fall && !adc_hben)           since_q <= '0;
      else if (since_q < CW'(CONV_CYC))   since_q <= since_q + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (adc_cs_n && adc_rd_n));

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rd_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_cs_n);

  p_hben_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_hben));

  p_conv_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |-> (since_q >= CW'(CONV_CYC - 1)));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_valid_in_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);
endmodule

bind adc_read_seq adc_read_seq_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_hben(adc_hben),
  .res_valid(res_valid)
);

// File: tb/adc_read_seq_tb.sv
`timescale 1ns/1ps
module adc_read_seq_tb;
  localparam int SETUP = 2, PULSE = 3, HOLD = 2, GAP = 4, CONV = 40;
  localparam int MODEL_CONV = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_slow = 1'b0, req_byte = 1'b0;
  logic req_ready, res_valid;
  logic [11:0] res_data;
  logic adc_cs_n, adc_rd_n, adc_hben;
  logic adc_busy_n = 1'b1;
  logic [11:0] adc_data;
  logic [11:0] latch_q = 12'hBAD;

  int checks = 0, errors = 0;
  int accepted = 0, pulses = 0, starts_pred = 0, conv_idx = 0;
  logic [11:0] exp_q[$];
  int          tag_q[$];

  always #2.5 clk = ~clk;

  adc_read_seq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                 .GAP_CYC(GAP), .CONV_CYC(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_slow(req_slow), .req_byte(req_byte), .res_valid(res_valid),
    .res_data(res_data), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_hben(adc_hben), .adc_busy_n(adc_busy_n), .adc_data(adc_data)
  );

  assign adc_data = adc_hben ? {latch_q[11:8], 4'b0000, latch_q[11:8]} : latch_q;

  function automatic logic [11:0] conv_val(input int idx);
    return 12'((idx * 1237 + 291) & 32'hFFF);
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model and strobe timing monitor
  logic rd_prev = 1'b1, cs_prev = 1'b1, hben_prev = 1'b0, had_rd = 1'b0, first_cs = 1'b1;
  int setup_c = 0, pulse_c = 0, hold_c = 0, gap_c = 0, conv_left = 0, cur_idx = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_busy_n) begin
        conv_left--;
        if (conv_left == 0) begin
          latch_q    = conv_val(cur_idx);
          adc_busy_n = 1'b1;
        end
      end
      if (!adc_cs_n && cs_prev) begin
        if (!first_cs) check(gap_c >= GAP, "R3", "cs high gap", gap_c, GAP);
        first_cs = 1'b0; setup_c = 0; had_rd = 1'b0;
      end
      if (!adc_cs_n && !cs_prev)
        check(adc_hben == hben_prev, "R3", "hben stable under cs", adc_hben, hben_prev);
      if (rd_prev && !adc_rd_n) begin
        check(!adc_cs_n, "R3", "cs low at rd fall", adc_cs_n, 0);
        check(setup_c >= SETUP, "R3", "cs setup", setup_c, SETUP);
        check(adc_busy_n, "R4", "read during conversion", adc_busy_n, 1);
        had_rd = 1'b1; pulse_c = 0;
        if (!adc_hben) begin
          cur_idx = conv_idx; conv_idx++;
          adc_busy_n = 1'b0; conv_left = MODEL_CONV;
        end
      end
      if (!rd_prev && adc_rd_n) begin
        check(pulse_c >= PULSE, "R3", "rd width", pulse_c, PULSE);
        hold_c = 0;
      end
      if (adc_cs_n && !cs_prev) begin
        check(hold_c >= HOLD, "R3", "cs hold", hold_c, HOLD);
        gap_c = 0;
      end
      if (!adc_cs_n && adc_rd_n && !had_rd) setup_c++;
      if (!adc_rd_n) pulse_c++;
      if (!adc_cs_n && adc_rd_n && had_rd) hold_c++;
      if (adc_cs_n) gap_c++;
    end
    rd_prev = adc_rd_n; cs_prev = adc_cs_n; hben_prev = adc_hben;
  end

  // scoreboard monitor
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      pulses++;
      check(!prev_valid, "R9", "valid longer than one cycle", 1, 0);
      check(res_data != 12'hBAD, "R9", "power-up data returned", res_data, 0);
      if (exp_q.size() == 0) check(0, "R2", "result with no request", pulses, accepted);
      else begin
        logic [11:0] e;
        int t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_data == e, mode_req(t), "result word", res_data, e);
      end
    end
    prev_valid = res_valid;
  end

  task automatic do_req(input bit slow, input bit two);
    @(negedge clk);
    req_valid = 1'b1; req_slow = slow; req_byte = two;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(conv_val(starts_pred));
    tag_q.push_back(slow ? (two ? 3 : 2) : (two ? 1 : 0));
    starts_pred += slow ? 1 : 2;
    accepted++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual %0d expected %0d", pulses, accepted);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(adc_cs_n && adc_rd_n, "R1", "strobes idle in reset", {adc_cs_n, adc_rd_n}, 3);
    check(!res_valid, "R1", "res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready, "R1", "ready after reset", req_ready, 1);
    check(adc_cs_n && adc_rd_n, "R1", "strobes idle after reset", {adc_cs_n, adc_rd_n}, 3);

    do_req(0, 0); do_req(0, 0);          // R5
    do_req(0, 1); do_req(0, 1);          // R6
    do_req(1, 0); do_req(1, 0);          // R7
    do_req(1, 1); do_req(1, 1);          // R8
    do_req(1, 0); do_req(0, 1); do_req(1, 1); do_req(0, 0);
    drain();

    // R2: valid offered while a request is in progress has no effect
    do_req(1, 0);
    for (int i = 0; i < 5; i++) begin
      check(!req_ready, "R2", "ready low while busy", req_ready, 0);
      req_valid = 1'b1; req_slow = 1'b0; req_byte = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    drain();
    repeat (200) @(negedge clk);
    check(pulses == accepted, "R2", "one result per accepted request", pulses, accepted);
    check(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    check(conv_idx == starts_pred, "R5", "conversion starts issued", conv_idx, starts_pred);
    check(req_ready && adc_cs_n, "R1", "idle at end", {req_ready, adc_cs_n}, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule